// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the bus-facing front end of a three-channel interval timer. A host writes 8-bit bytes at a 2-bit address. Address 3 carries a configuration word. Addresses 0 to 2 carry count bytes for the channel of the same number. The block keeps each channel's configuration: operating mode, decimal or binary flag, and byte access format.

It assembles one- or two-byte count loads and hands each finished value to its counting engine with a single-cycle strobe. The counting engine sits outside this block. It is expected to move the value into its count register only after a rising and then a falling edge of its own counting clock.

Reads return bytes of a channel's count. By default this is the live value supplied by the engine. After a latch command, reads return a frozen snapshot until all bytes of that snapshot have been read. Bus accesses are sampled on the rising edge of the system clock, qualified by chip-select and separate read and write strobes. Read data is combinational from the address while a read is active.

Top module: `tmr_host_if`

## Requirements
- R1: An access with `cs_i` high is decoded by `addr_i`: value 3 selects the configuration word, and values 0, 1 and 2 select channel 0, 1 and 2 count bytes.
- R2: A configuration word is decoded as follows.
  - Bits 7:6 select the channel.
  - Bits 5:4 select the format: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte.
  - Bits 3:1 give the mode. 000, 001, 100 and 101 give modes 0, 1, 4 and 5. x10 gives mode 2 and x11 gives mode 3.
  - Bit 0 is the decimal flag.
  - Channel c reports its mode on `mode_o[3c+2:3c]` and its flag on `bcd_o[c]`, from the cycle after the write.
- R3: A configuration word whose bits 7:6 are 11 changes no mode, flag, format or count.
- R4: In low-byte-only format, a data write of byte d sets the channel count to {8'h00,d}. `load_o[c]` is high in the next cycle.
- R5: In high-byte-only format, a data write of byte d sets the channel count to {d,8'h00}. `load_o[c]` is high in the next cycle.
- R6: In two-byte format, the first data write neither changes `count_o` nor strobes `load_o`. The second write sets the count to {second,first} and strobes `load_o[c]` in the next cycle.
- R7: A non-latch configuration word for a channel restarts its write and read byte sequence at the low byte.
- R8: A read returns the low count byte in low-only format and the high byte in high-only format. In two-byte format, successive reads alternate low then high.
- R9: A latch command (format 00) captures the channel's live count. Reads return the captured bytes until the format's last byte is read. After that, reads return the live count again.
- R10: A latch command issued while an earlier capture is still unread is ignored.
- R11: A latch command leaves the channel's mode, flag and format unchanged.
- R12: After reset every channel reports mode 0, binary, low-only format, count 0 and no load strobe. `rdata_o` is 0 when no read is active.
- R13: A load strobe lasts one cycle, and at most one channel strobes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write byte |
| rdata_o | output | DATA_W | Read byte |
| live_cnt_i | input | 3*CNT_W | Live count of each channel from its engine |
| mode_o | output | 9 | Decoded mode, 3 bits per channel |
| bcd_o | output | 3 | Decimal counting flag per channel |
| count_o | output | 3*CNT_W | Last complete count loaded per channel |
| load_o | output | 3 | One-cycle strobe when a channel's count is complete |

## Verification
Configuration words cover every channel select, including the illegal one. They also cover both spellings of modes 2 and 3, so that channel routing and the mode folding can be told apart.

Count loads are tried in all three byte formats with distinct byte values. A swapped byte order, a missing zero fill or a premature strobe therefore each give a different result. A half-finished two-byte load is interrupted by a configuration rewrite to expose a pointer that is not reset.

Reads run against changing live counts. This separates captured data from live data, shows the point at which a capture is released, and shows that a second latch during an unread capture keeps the first snapshot.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 3;
  localparam logic [1:0] CTRL_ADDR = 2'b11;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'b00,
    FMT_LSB   = 2'b01,
    FMT_MSB   = 2'b10,
    FMT_BOTH  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [1:0] sel;
    fmt_e       fmt;
    logic [2:0] mode;  // folded to 0..5
    logic       bcd;
  } cw_t;
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_pkg::*;
(
  input  logic [7:0] byte_i,
  output cw_t        cw_o,
  output logic       legal_o
);
  logic [2:0] raw_mode;

  always_comb begin
    raw_mode    = byte_i[3:1];
    cw_o.sel    = byte_i[7:6];
    cw_o.fmt    = fmt_e'(byte_i[5:4]);
    cw_o.bcd    = byte_i[0];
    // x10 -> 2, x11 -> 3, others pass through
    cw_o.mode   = raw_mode[1] ? {2'b01, raw_mode[0]} : raw_mode;
    legal_o     = (byte_i[7:6] != 2'b11);
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_we_i,
  input  logic              latch_i,
  input  cw_t               cw_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              rd_adv_i,
  input  logic [CNT_W-1:0]  live_i,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] rbyte_o
);
  localparam int HI_W = CNT_W - BYTE_W;

  fmt_e              fmt_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic [CNT_W-1:0]  count_q;
  logic [BYTE_W-1:0] stage_q;
  logic              wptr_q;
  logic              rptr_q;
  logic              lat_vld_q;
  logic [CNT_W-1:0]  lat_q;
  logic              load_q;

  logic [CNT_W-1:0]  src;
  logic              hi_sel;
  logic              read_done;

  always_comb begin
    src       = lat_vld_q ? lat_q : live_i;
    hi_sel    = (fmt_q == FMT_MSB) || ((fmt_q == FMT_BOTH) && rptr_q);
    rbyte_o   = hi_sel ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    read_done = (fmt_q != FMT_BOTH) || rptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q     <= FMT_LSB;
      mode_q    <= '0;
      bcd_q     <= 1'b0;
      count_q   <= '0;
      stage_q   <= '0;
      wptr_q    <= 1'b0;
      rptr_q    <= 1'b0;
      lat_vld_q <= 1'b0;
      lat_q     <= '0;
      load_q    <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (cw_we_i) begin
        fmt_q     <= cw_i.fmt;
        mode_q    <= cw_i.mode;
        bcd_q     <= cw_i.bcd;
        wptr_q    <= 1'b0;
        rptr_q    <= 1'b0;
        lat_vld_q <= 1'b0;
      end else begin
        if (latch_i && !lat_vld_q) begin
          lat_q     <= live_i;
          lat_vld_q <= 1'b1;
        end
        if (data_we_i) begin
          unique case (fmt_q)
            FMT_LSB: begin
              count_q <= {{HI_W{1'b0}}, data_i};
              load_q  <= 1'b1;
            end
            FMT_MSB: begin
              count_q <= {data_i, {(CNT_W-BYTE_W){1'b0}}};
              load_q  <= 1'b1;
            end
            FMT_BOTH: begin
              if (!wptr_q) begin
                stage_q <= data_i;
                wptr_q  <= 1'b1;
              end else begin
                count_q <= {data_i, stage_q};
                wptr_q  <= 1'b0;
                load_q  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (rd_adv_i) begin
          if (fmt_q == FMT_BOTH) rptr_q <= ~rptr_q;
          if (read_done) lat_vld_q <= 1'b0;
        end
      end
    end
  end

  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;
  assign count_o = count_q;
  assign load_o  = load_q;
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NCH*CNT_W-1:0]  live_cnt_i,
  output logic [NCH*3-1:0]      mode_o,
  output logic [NCH-1:0]        bcd_o,
  output logic [NCH*CNT_W-1:0]  count_o,
  output logic [NCH-1:0]        load_o
);
  logic wr_en, rd_en, cw_hit, cw_legal;
  cw_t  cw;
  logic [DATA_W-1:0] rbyte [NCH];

  assign wr_en  = cs_i && wr_i;
  assign rd_en  = cs_i && rd_i;
  assign cw_hit = wr_en && (addr_i == CTRL_ADDR);

  tmr_cw_decode u_dec (
    .byte_i  (wdata_i[7:0]),
    .cw_o    (cw),
    .legal_o (cw_legal)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic sel_hit;
    assign sel_hit = cw_hit && cw_legal && (cw.sel == 2'(ch));

    tmr_chan_regs #(.BYTE_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cw_we_i   (sel_hit && (cw.fmt != FMT_LATCH)),
      .latch_i   (sel_hit && (cw.fmt == FMT_LATCH)),
      .cw_i      (cw),
      .data_we_i (wr_en && (addr_i == 2'(ch))),
      .data_i    (wdata_i),
      .rd_adv_i  (rd_en && (addr_i == 2'(ch))),
      .live_i    (live_cnt_i[ch*CNT_W +: CNT_W]),
      .mode_o    (mode_o[ch*3 +: 3]),
      .bcd_o     (bcd_o[ch]),
      .count_o   (count_o[ch*CNT_W +: CNT_W]),
      .load_o    (load_o[ch]),
      .rbyte_o   (rbyte[ch])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        2'd0:    rdata_o = rbyte[0];
        2'd1:    rdata_o = rbyte[1];
        2'd2:    rdata_o = rbyte[2];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [1:0]            addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NCH*CNT_W-1:0]  live_cnt_i,
  input logic [NCH*3-1:0]      mode_o,
  input logic [NCH-1:0]        bcd_o,
  input logic [NCH*CNT_W-1:0]  count_o,
  input logic [NCH-1:0]        load_o
);
  p_load_onehot_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  p_illegal_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && addr_i == 2'b11 && wdata_i[7:6] == 2'b11)
    |=> ($stable(mode_o) && $stable(bcd_o) && $stable(count_o)));

  p_latch_keeps_cfg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && addr_i == 2'b11 && wdata_i[5:4] == 2'b00)
    |=> ($stable(mode_o) && $stable(bcd_o)));

  p_count_needs_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i && addr_i != 2'b11) |=> $stable(count_o));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    p_load_after_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[ch] |-> $past(cs_i && wr_i && addr_i == 2'(ch)));

    p_mode_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[ch*3 +: 3] <= 3'd5);
  end
endmodule

bind tmr_host_if tmr_host_if_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr_host_if.sv
`timescale 1ns/100ps
module tb_tmr_host_if;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [47:0] live_cnt_i = '0;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [47:0] count_o;
  logic [2:0]  load_o;

  int checks = 0, errors = 0;
  logic [2:0] last_load;
  logic [7:0] rd_val;

  always #2.5 clk_i = ~clk_i;

  tmr_host_if dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
    #0.5 last_load = load_o;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #0.5 d = rdata_o;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  function automatic logic [2:0] mode_of(int ch);
    return mode_o[ch*3 +: 3];
  endfunction

  function automatic logic [15:0] cnt_of(int ch);
    return count_o[ch*16 +: 16];
  endfunction

  task automatic t_reset();
    #0.5;
    check("R12 mode", 32'(mode_o), 0);
    check("R12 bcd", 32'(bcd_o), 0);
    check("R12 count", 32'(count_o[31:0]), 0);
    check("R12 load", 32'(load_o), 0);
    check("R12 rdata idle", 32'(rdata_o), 0);
  endtask

  task automatic t_cw_fields();
    bus_wr(2'd3, 8'h7D);  // ch1 both, raw 110, bcd
    bus_wr(2'd3, 8'h9E);  // ch2 lsb, raw 111
    bus_wr(2'd3, 8'h2A);  // ch0 msb, raw 101
    check("R2 ch1 mode 110->2", 32'(mode_of(1)), 2);
    check("R2 ch1 bcd", 32'(bcd_o[1]), 1);
    check("R2 ch2 mode 111->3", 32'(mode_of(2)), 3);
    check("R1 ch0 mode 5", 32'(mode_of(0)), 5);
    check("R2 ch0 bcd", 32'(bcd_o[0]), 0);
  endtask

  task automatic t_illegal();
    logic [8:0] m = mode_o;
    logic [2:0] b = bcd_o;
    bus_wr(2'd3, 8'hFF);
    check("R3 mode kept", 32'(mode_o), 32'(m));
    check("R3 bcd kept", 32'(bcd_o), 32'(b));
  endtask

  task automatic t_lsb();
    bus_wr(2'd3, 8'h18);  // ch0 lsb mode 4
    check("R2 ch0 mode 4", 32'(mode_of(0)), 4);
    bus_wr(2'd0, 8'hA5);
    check("R4 load", 32'(last_load), 3'b001);
    check("R4 count", 32'(cnt_of(0)), 16'h00A5);
    #5 check("R13 load one cycle", 32'(load_o), 0);
  endtask

  task automatic t_msb();
    bus_wr(2'd3, 8'hA0);  // ch2 msb mode 0
    bus_wr(2'd2, 8'h3C);
    check("R5 load", 32'(last_load), 3'b100);
    check("R5 count", 32'(cnt_of(2)), 16'h3C00);
  endtask

  task automatic t_two_byte();
    bus_wr(2'd1, 8'h34);
    check("R6 no load on first", 32'(last_load), 0);
    check("R6 count held", 32'(cnt_of(1)), 0);
    bus_wr(2'd1, 8'h12);
    check("R6 load", 32'(last_load), 3'b010);
    check("R6 count", 32'(cnt_of(1)), 16'h1234);
  endtask

  task automatic t_ptr_reset();
    bus_wr(2'd1, 8'h56);
    bus_wr(2'd3, 8'h7D);
    bus_wr(2'd1, 8'h78);
    check("R7 restart low byte", 32'(last_load), 0);
    bus_wr(2'd1, 8'h9A);
    check("R7 count", 32'(cnt_of(1)), 16'h9A78);
  endtask

  task automatic t_read_fmt();
    live_cnt_i = {16'h1357, 16'hCAFE, 16'hBEEF};
    bus_rd(2'd0, rd_val); check("R8 lsb-only", 32'(rd_val), 8'hEF);
    bus_rd(2'd0, rd_val); check("R8 lsb-only again", 32'(rd_val), 8'hEF);
    bus_rd(2'd2, rd_val); check("R8 msb-only", 32'(rd_val), 8'h13);
    bus_rd(2'd1, rd_val); check("R8 both low", 32'(rd_val), 8'hFE);
    bus_rd(2'd1, rd_val); check("R8 both high", 32'(rd_val), 8'hCA);
    bus_rd(2'd1, rd_val); check("R8 both low again", 32'(rd_val), 8'hFE);
    bus_rd(2'd3, rd_val); check("R1 ctrl read zero", 32'(rd_val), 0);
  endtask

  task automatic t_latch();
    bus_wr(2'd3, 8'h7D);  // restart read sequence
    bus_wr(2'd3, 8'h40);  // latch ch1
    live_cnt_i[31:16] = 16'h1111;
    bus_rd(2'd1, rd_val); check("R9 latched low", 32'(rd_val), 8'hFE);
    bus_rd(2'd1, rd_val); check("R9 latched high", 32'(rd_val), 8'hCA);
    bus_rd(2'd1, rd_val); check("R9 live after release", 32'(rd_val), 8'h11);
    bus_rd(2'd1, rd_val); check("R9 live high", 32'(rd_val), 8'h11);
  endtask

  task automatic t_double_latch();
    live_cnt_i[31:16] = 16'h2222;
    bus_wr(2'd3, 8'h40);
    live_cnt_i[31:16] = 16'h3333;
    bus_rd(2'd1, rd_val); check("R10 first capture low", 32'(rd_val), 8'h22);
    bus_wr(2'd3, 8'h40);
    live_cnt_i[31:16] = 16'h4444;
    bus_rd(2'd1, rd_val); check("R10 second latch ignored", 32'(rd_val), 8'h22);
    bus_rd(2'd1, rd_val); check("R10 live afterwards", 32'(rd_val), 8'h44);
    check("R11 mode kept", 32'(mode_of(1)), 2);
    check("R11 bcd kept", 32'(bcd_o[1]), 1);
    bus_wr(2'd1, 8'h01);
    check("R11 format kept", 32'(last_load), 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    t_reset();
    t_cw_fields();
    t_illegal();
    t_lsb();
    t_msb();
    t_two_byte();
    t_ptr_reset();
    t_read_fmt();
    t_latch();
    t_double_latch();
    #20;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule